// File: doc/BRIEF.md
# Address-as-data memory test engine

This block runs a destructive self-test over a word memory of 32-bit words. It drives a synchronous memory port one access per cycle. A test has two passes. The first pass writes every word in the selected region with its own word address, then reads the region back and checks each word against that address. The second pass does the same with the bitwise complement of the address. The first word that reads back wrong ends the test. The engine then reports the failing address and an error code that identifies both the region and the pass.

The region is either the whole memory, treated as one contiguous space of two banks, or a single bank. Bank size is a parameter. A coarse progress counter counts the chunks of `STEP_WORDS` words that have been touched in the current phase. With the default sizes it counts 1 to 8 over the whole memory, one step per 128 KiB. The phase and pass outputs show where the engine is in the test.

Top module: `memtest_engine`

## Requirements
- R1: After reset, `mem_req`, `busy`, `done`, `fail` and `pass_inv` are 0, and `err_code`, `err_addr` and `progress` are 0.
- R2: A `start` pulse in idle, or after a finished test, latches `region` and begins a test. The codes are 0 or 3 for the whole memory (base 0, `2*BANK_WORDS` words), 1 for the lower bank (base 0, `BANK_WORDS` words) and 2 for the upper bank (base `BANK_WORDS`, `BANK_WORDS` words). A `start` while `busy` is 1 has no effect on the running test.
- R3: The first cycle after the accepted start begins the fill phase. In each fill cycle `mem_req`=1, `mem_we`=1 and `phase_read`=0. Addresses rise by one from the region base, and in the direct pass `mem_wdata` is the word address zero-extended to 32 bits.
- R4: The read phase follows the last fill cycle directly. In each read cycle `mem_req`=1, `mem_we`=0 and `phase_read`=1, with addresses rising from the base. One drain cycle follows it, with `mem_req`=0, `phase_read`=1 and `busy`=1.
- R5: `mem_rdata` is taken one cycle after its read request. It is compared with the pattern for the address of that request.
- R6: After a direct pass that verifies without error, the next cycle starts a second fill with `pass_inv`=1. That pass writes and checks the 32-bit bitwise complement of the zero-extended address.
- R7: In every cycle with `mem_req`=1, `progress` equals 1 plus the offset of the current address from the region base, divided by `STEP_WORDS` and rounded down. It restarts at 1 at each phase.
- R8: On the first mismatch, the next cycle shows `done`=1, `fail`=1, `mem_req`=0 and `busy`=0, with `err_addr` set to the address of the word that failed. No later word is checked.
- R9: `err_code` on failure is 11 or 12 for the whole memory, 13 or 14 for the lower bank, and 15 or 16 for the upper bank. The lower number of each pair is the direct pass and the higher is the inverted pass.
- R10: When the drain cycle of the inverted pass passes its check, the next cycle shows `done`=1, `fail`=0, `err_code`=0 and `busy`=0.
- R11: `done`, `fail`, `err_code` and `err_addr` hold until the next accepted start, which clears them in the first cycle of the new test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test (ignored while busy) |
| region | input | 2 | Region select: 0/3 whole memory, 1 lower bank, 2 upper bank |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | $clog2(2*BANK_WORDS) | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Test in progress |
| phase_read | output | 1 | 0 fill phase, 1 read phase |
| pass_inv | output | 1 | 0 direct pass, 1 inverted pass |
| progress | output | $clog2(MAX_STEPS+1) | Chunk counter for the current phase |
| done | output | 1 | Test finished |
| fail | output | 1 | Test finished with a mismatch |
| err_code | output | 8 | Region and pass code of the failure, 0 otherwise |
| err_addr | output | $clog2(2*BANK_WORDS) | Address of the failing word |

## Verification
The bench places a stuck-at-one bit on a single word of its memory model. It picks the bit so that only the direct pass fails, or only the inverted pass. A design that compared against the wrong pass's pattern, or that did not register the read address, would then report the wrong code or an address off by one. The faults sit at the first word and the last word of a region, where an early exit from the drain cycle would miss the last compare. A fault placed outside the selected bank must go unnoticed, which shows that the region bounds hold. A start pulse issued mid-test checks that the engine does not restart or change region, and the progress value is checked on every access to catch a step that comes one word late.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  localparam int DATA_W = 32;

  localparam logic [1:0] SEL_FULL  = 2'd0;
  localparam logic [1:0] SEL_LOWER = 2'd1;
  localparam logic [1:0] SEL_UPPER = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_READ,
    ST_DRAIN,
    ST_END
  } state_e;

  // Data pattern for a word: its address, or the complement of it.
  function automatic logic [DATA_W-1:0] word_pattern(logic [DATA_W-1:0] a, logic inv);
    return inv ? ~a : a;
  endfunction

  function automatic int unsigned region_base(logic [1:0] sel, int unsigned bank);
    return (sel == SEL_UPPER) ? bank : 0;
  endfunction

  function automatic int unsigned region_len(logic [1:0] sel, int unsigned bank);
    return (sel == SEL_LOWER || sel == SEL_UPPER) ? bank : 2 * bank;
  endfunction

  function automatic logic [7:0] fault_code(logic [1:0] sel, logic inv);
    logic [7:0] c;
    if (sel == SEL_LOWER)      c = 8'd13;
    else if (sel == SEL_UPPER) c = 8'd15;
    else                       c = 8'd11;
    return c + {7'd0, inv};
  endfunction

  // Chunk number (from 1) that holds a given offset.
  function automatic int unsigned step_index(int unsigned off, int unsigned step);
    return off / step + 1;
  endfunction

endpackage

// File: rtl/memtest_walker.sv
module memtest_walker import memtest_pkg::*; #(
  parameter int AW = 18,
  parameter int STEP_WORDS = 32768,
  parameter int PW = 4,
  localparam int LW = AW + 1,
  localparam int SW = (STEP_WORDS > 1) ? $clog2(STEP_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          last,
  output logic [PW-1:0] progress
);

  logic [AW-1:0] addr_q, off_q;
  logic [LW-1:0] len_q;
  logic [SW-1:0] in_step_q;
  logic [PW-1:0] prog_q;
  logic          step_wrap;

  assign step_wrap = (in_step_q == SW'(STEP_WORDS - 1));
  assign last      = ({1'b0, off_q} == len_q - LW'(1));
  assign addr      = addr_q;
  assign progress  = prog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      off_q     <= '0;
      len_q     <= '0;
      in_step_q <= '0;
      prog_q    <= '0;
    end else if (load) begin
      addr_q    <= base;
      off_q     <= '0;
      len_q     <= len;
      in_step_q <= '0;
      prog_q    <= PW'(1);
    end else if (adv) begin
      addr_q <= addr_q + AW'(1);
      off_q  <= off_q + AW'(1);
      if (step_wrap) begin
        in_step_q <= '0;
        prog_q    <= prog_q + PW'(1);
      end else begin
        in_step_q <= in_step_q + SW'(1);
      end
    end
  end

  // R7
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q != '0) |-> (prog_q == PW'(step_index(32'(off_q), STEP_WORDS))));

endmodule

// File: rtl/memtest_verify.sv
module memtest_verify import memtest_pkg::*; #(
  parameter int AW = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [AW-1:0]     addr,
  input  logic              inv,
  input  logic [DATA_W-1:0] rdata,
  output logic              cmp_valid,
  output logic [AW-1:0]     cmp_addr,
  output logic              mismatch
);

  logic              valid_q, inv_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] expect_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      inv_q   <= 1'b0;
    end else begin
      valid_q <= issue;
      if (issue) begin
        addr_q <= addr;
        inv_q  <= inv;
      end
    end
  end

  assign expect_w  = word_pattern(DATA_W'(addr_q), inv_q);
  assign mismatch  = valid_q && (rdata != expect_w);
  assign cmp_valid = valid_q;
  assign cmp_addr  = addr_q;

  // R8
  halt_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> !issue);

  // R5
  compare_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (cmp_valid && cmp_addr == $past(addr)));

endmodule

// File: rtl/memtest_ctrl.sv
module memtest_ctrl import memtest_pkg::*; #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    region,
  input  logic          last,
  input  logic          cmp_valid,
  input  logic          mismatch,
  input  logic [AW-1:0] cmp_addr,
  output logic [1:0]    region_act,
  output logic          load,
  output logic          adv,
  output logic          req,
  output logic          we,
  output logic          read_phase,
  output logic          inv,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [7:0]    err_code,
  output logic [AW-1:0] err_addr
);

  state_e        st_q, st_d;
  logic          inv_q, done_q, fail_q;
  logic [1:0]    region_q;
  logic [7:0]    code_q;
  logic [AW-1:0] eaddr_q;
  logic          go, pass_ok, checking, miss_hit;

  always_comb begin
    go         = start && (st_q == ST_IDLE || st_q == ST_END);
    region_act = go ? region : region_q;
    req        = (st_q == ST_FILL) || (st_q == ST_READ);
    we         = (st_q == ST_FILL);
    read_phase = (st_q == ST_READ) || (st_q == ST_DRAIN);
    busy       = req || (st_q == ST_DRAIN);
    adv        = req && !last;
    checking   = read_phase;
    miss_hit   = checking && mismatch;
    pass_ok    = (st_q == ST_DRAIN) && cmp_valid && !mismatch;
    load       = go || ((st_q == ST_FILL) && last) || (pass_ok && !inv_q);

    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_END: if (go) st_d = ST_FILL;
      ST_FILL:         if (last) st_d = ST_READ;
      ST_READ: begin
        if (miss_hit)  st_d = ST_END;
        else if (last) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (miss_hit)     st_d = ST_END;
        else if (pass_ok) st_d = inv_q ? ST_END : ST_FILL;
      end
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      inv_q    <= 1'b0;
      region_q <= SEL_FULL;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      code_q   <= '0;
      eaddr_q  <= '0;
    end else begin
      st_q <= st_d;
      if (go) begin
        inv_q    <= 1'b0;
        region_q <= region;
        done_q   <= 1'b0;
        fail_q   <= 1'b0;
        code_q   <= '0;
        eaddr_q  <= '0;
      end else if (miss_hit) begin
        done_q  <= 1'b1;
        fail_q  <= 1'b1;
        code_q  <= fault_code(region_q, inv_q);
        eaddr_q <= cmp_addr;
      end else if (pass_ok) begin
        if (inv_q) done_q <= 1'b1;
        else       inv_q  <= 1'b1;
      end
    end
  end

  assign inv      = inv_q;
  assign done     = done_q;
  assign fail     = fail_q;
  assign err_code = code_q;
  assign err_addr = eaddr_q;

  // R6
  inverse_after_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_q) |-> (!fail_q && req && we));

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine import memtest_pkg::*; #(
  parameter int BANK_WORDS = 131072,
  parameter int STEP_WORDS = 32768,
  localparam int AW = $clog2(2 * BANK_WORDS),
  localparam int LW = AW + 1,
  localparam int MAX_STEPS = (2 * BANK_WORDS + STEP_WORDS - 1) / STEP_WORDS,
  localparam int PW = $clog2(MAX_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        region,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              phase_read,
  output logic              pass_inv,
  output logic [PW-1:0]     progress,
  output logic              done,
  output logic              fail,
  output logic [7:0]        err_code,
  output logic [AW-1:0]     err_addr
);

  logic [1:0]    region_act;
  logic          load, adv, last;
  logic          cmp_valid, mismatch;
  logic [AW-1:0] cmp_addr;
  logic [AW-1:0] base_w;
  logic [LW-1:0] len_w;

  assign base_w = AW'(region_base(region_act, BANK_WORDS));
  assign len_w  = LW'(region_len(region_act, BANK_WORDS));

  memtest_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .region(region),
    .last(last), .cmp_valid(cmp_valid), .mismatch(mismatch), .cmp_addr(cmp_addr),
    .region_act(region_act), .load(load), .adv(adv), .req(mem_req), .we(mem_we),
    .read_phase(phase_read), .inv(pass_inv), .busy(busy), .done(done), .fail(fail),
    .err_code(err_code), .err_addr(err_addr)
  );

  memtest_walker #(.AW(AW), .STEP_WORDS(STEP_WORDS), .PW(PW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base_w), .len(len_w), .adv(adv),
    .addr(mem_addr), .last(last), .progress(progress)
  );

  assign mem_wdata = word_pattern(DATA_W'(mem_addr), pass_inv);

  memtest_verify #(.AW(AW)) u_vfy (
    .clk(clk), .rst_n(rst_n), .issue(mem_req && !mem_we), .addr(mem_addr),
    .inv(pass_inv), .rdata(mem_rdata), .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
    .mismatch(mismatch)
  );

  // R2
  region_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ({1'b0, mem_addr} >= {1'b0, base_w} &&
                 {1'b0, mem_addr} <  {1'b0, base_w} + len_w));

  // R3
  ascending_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && phase_read == $past(phase_read))
      |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R4
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && phase_read) |-> !mem_we);

  // R9
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (err_code >= 8'd11 && err_code <= 8'd16));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail) && $stable(err_code) && $stable(err_addr)));

endmodule

// File: tb/sim_memtest_engine.sv
`timescale 1ns/1ps
module sim_memtest_engine;
  localparam int BW = 64;
  localparam int SW = 16;
  localparam int AW = $clog2(2 * BW);
  localparam int PW = $clog2((2 * BW + SW - 1) / SW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    region = 2'd0;
  logic          mem_req, mem_we, busy, phase_read, pass_inv, done, fail;
  logic [AW-1:0] mem_addr, err_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = 32'd0;
  logic [PW-1:0] progress;
  logic [7:0]    err_code;

  int n_chk = 0;
  int n_err = 0;
  int flt_addr = -1;
  logic [31:0] flt_mask = 32'd0;
  logic [31:0] mem [0:2*BW-1];

  always #2.5 clk = ~clk;

  memtest_engine #(.BANK_WORDS(BW), .STEP_WORDS(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .region(region),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .phase_read(phase_read), .pass_inv(pass_inv),
    .progress(progress), .done(done), .fail(fail), .err_code(err_code), .err_addr(err_addr)
  );

  // Memory model with one stuck-at-one bit field on a chosen word.
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we)
      mem_rdata <= mem[mem_addr] | ((int'(mem_addr) == flt_addr) ? flt_mask : 32'd0);
  end

  function automatic logic [31:0] mask_of(int a);
    return (a == flt_addr) ? flt_mask : 32'd0;
  endfunction

  function automatic logic [31:0] pat_of(int a, int p);
    logic [31:0] v;
    v = a;
    return (p != 0) ? (v ^ 32'hFFFF_FFFF) : v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic step(inout int cyc, input int poke, input logic [1:0] sel);
    if (cyc == poke) begin
      start  = 1'b1;
      region = (sel == 2'd1) ? 2'd2 : 2'd1;
    end
    @(negedge clk);
    start  = 1'b0;
    region = sel;
    cyc++;
  endtask

  task automatic run_case(input logic [1:0] sel, input int fa, input logic [31:0] fm, input int poke);
    int eff, base, len, cbase, cyc, fail_at, exp_code, a;
    bit failed;
    flt_addr = fa;
    flt_mask = fm;
    eff   = (sel == 2'd3) ? 0 : int'(sel);
    base  = (eff == 2) ? BW : 0;
    len   = (eff == 0) ? 2 * BW : BW;
    cbase = (eff == 0) ? 11 : ((eff == 1) ? 13 : 15);
    failed = 1'b0; fail_at = 0; exp_code = 0; cyc = 0;
    start = 1'b1; region = sel;
    @(negedge clk);
    start = 1'b0;
    chk("R11 cleared on start", 64'({done, fail, err_code}), 64'd0);
    for (int p = 0; p < 2 && !failed; p++) begin
      for (int i = 0; i < len; i++) begin
        a = base + i;
        chk("R3 fill controls", 64'({mem_req, mem_we, phase_read, busy, done}), 64'(5'b11010));
        chk("R3 fill addr", 64'(mem_addr), 64'(a));
        chk((p != 0) ? "R6 fill data" : "R3 fill data", 64'(mem_wdata), 64'(pat_of(a, p)));
        chk("R6 pass flag", 64'(pass_inv), 64'(p));
        chk("R7 progress", 64'(progress), 64'(i / SW + 1));
        step(cyc, poke, sel);
      end
      for (int j = 0; j <= len; j++) begin
        if (j < len) begin
          chk("R4 read controls", 64'({mem_req, mem_we, phase_read, busy}), 64'(4'b1011));
          chk("R4 read addr", 64'(mem_addr), 64'(base + j));
          chk("R7 progress", 64'(progress), 64'(j / SW + 1));
        end else begin
          chk("R4 drain cycle", 64'({mem_req, phase_read, busy, done}), 64'(4'b0110));
        end
        if (j > 0) begin
          a = base + j - 1;
          if ((pat_of(a, p) | mask_of(a)) !== pat_of(a, p)) begin
            failed = 1'b1; fail_at = a; exp_code = cbase + p;
          end
        end
        step(cyc, poke, sel);
        if (failed) break;
      end
    end
    chk("R8 stop and finish", 64'({mem_req, busy, done}), 64'(3'b001));
    chk(failed ? "R8 fail flag" : "R10 fail flag", 64'(fail), 64'(failed));
    chk(failed ? "R9 error code" : "R10 clean code", 64'(err_code), 64'(exp_code));
    chk("R8 failing address", 64'(err_addr), 64'(failed ? fail_at : 0));
    if (poke >= 0) chk("R2 start while busy ignored", 64'({done, fail}), 64'(2'b10));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 result hold", 64'({done, fail, err_code, err_addr}),
          64'({1'b1, failed, exp_code[7:0], (failed ? AW'(fail_at) : AW'(0))}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 2 * BW; i++) mem[i] = 32'hA5C3_0000 ^ i;
    repeat (3) @(negedge clk);
    chk("R1 reset flags", 64'({mem_req, busy, done, fail, pass_inv}), 64'd0);
    chk("R1 reset values", 64'({err_code, err_addr, progress}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 64'({mem_req, busy, done}), 64'd0);
    run_case(2'd0, -1, 32'd0, -1);            // R2 R10 whole memory
    run_case(2'd1, -1, 32'd0, -1);            // R2 lower bank
    run_case(2'd2, -1, 32'd0, -1);            // R2 upper bank
    run_case(2'd3, -1, 32'd0, -1);            // R2 code 3 = whole memory
    run_case(2'd0, 70, 32'h1, -1);            // R9 code 11
    run_case(2'd0, 70, 32'h2, -1);            // R9 code 12
    run_case(2'd1, 5, 32'h2, -1);             // R9 code 13
    run_case(2'd1, 5, 32'h1, -1);             // R9 code 14
    run_case(2'd2, 73, 32'h2, -1);            // R9 code 15
    run_case(2'd2, 73, 32'h1, -1);            // R9 code 16
    run_case(2'd0, 0, 32'h1, -1);             // R5 first word
    run_case(2'd1, 63, 32'h40, -1);           // R5 last word, drain compare
    run_case(2'd2, 5, 32'h2, -1);             // R2 fault outside bank unseen
    run_case(2'd0, -1, 32'd0, 10);            // R2 start pulse while busy
    summary();
  end

endmodule